// File: doc/BRIEF.md
# Nonvolatile Memory Guard Register Bank

This block is a pair of byte-wide control registers inside an on-chip nonvolatile memory controller. Software reaches them over a simple bus. The bus has an address, a write strobe, write data and read data that is combinational from the address.

The configuration register holds two interrupt enables and a key-access mode bit. The key-access bit decides how the rest of the controller treats traffic to the array. When it is set, array writes are routed as backdoor-key writes and array reads are flagged invalid.

The protection register carries the sector protection settings. It is loaded from a nonvolatile image byte while reset is held. After reset, software can only tighten protection, never loosen it. Each range-size field freezes once the disable bit of its range has been cleared.

Top module: `nvm_guard_regs`

## Requirements
- R1: All configuration bits are 0 after reset. Configuration bits 4:0 always read 0, and writes to them are ignored.
- R2: Configuration bit 7 (buffer-empty interrupt enable) and bit 6 (command-complete interrupt enable) take the written value on every write to the configuration offset.
- R3: Configuration bit 5 (key access) takes the written value only while `keyEnable` is 1. Otherwise a write leaves it unchanged.
- R4: `irqReq` is 1 exactly when (bit 7 is 1 and `bufEmptyFlag` is 1) or (bit 6 is 1 and `cmdDoneFlag` is 1). It responds combinationally.
- R5: `keyWriteRoute` and `arrayReadInvalid` both equal configuration bit 5. When they are 0, array writes start a command sequence.
- R6: Each clock edge with `rstN` low loads the protection register from `nvImage`.
- R7: Protection bit 7 (open), bit 5 (high-range disable) and bit 2 (low-range disable) can change from 1 to 0 through a write, but never from 0 to 1.
- R8: Protection bit 6 is read-only. It keeps the value loaded from `nvImage`.
- R9: Protection bits 4:3 (high-range size) take written data only while bit 5 is 1. Bits 1:0 (low-range size) take written data only while bit 2 is 1. The value of the disable bit before the write decides this.
- R10: The configuration register is at offset 3 and the protection register at offset 4. Reads of any other offset return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | ADDR_W | Register offset |
| busWrEn | input | 1 | Write strobe, one write per cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` |
| nvImage | input | 8 | Protection value loaded during reset |
| keyEnable | input | 1 | Backdoor-key use permitted |
| bufEmptyFlag | input | 1 | Command buffer empty flag |
| cmdDoneFlag | input | 1 | All commands complete flag |
| irqReq | output | 1 | Combined interrupt request |
| keyWriteRoute | output | 1 | Array writes are backdoor-key writes |
| arrayReadInvalid | output | 1 | Array reads return invalid data |

## Verification
The assertions assume that `rstN` is held low for at least one clock edge before any check applies. They also assume that `busAddr` and the flag inputs settle between edges, because the read and interrupt paths are combinational. The stimulus changes every input only on the falling clock edge. It holds reset across two rising edges, and it drives a new `nvImage` only while reset is low. The bench varies `keyEnable` around configuration writes, so the key-access lock is exercised in both states.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
  localparam int DATA_W      = 8;
  localparam int CFG_CBE_BIT = 7;
  localparam int CFG_CC_BIT  = 6;
  localparam int CFG_KEY_BIT = 5;
  localparam int PROT_OPEN   = 7;
  localparam int PROT_NV     = 6;
  localparam int PROT_HDIS   = 5;
  localparam int PROT_HSZ    = 3;
  localparam int PROT_LDIS   = 2;
  localparam int PROT_LSZ    = 0;

  typedef struct packed {
    logic cfgWr;
    logic protWr;
    logic keyWrOk;
    logic rdCfg;
    logic rdProt;
  } strobeT;
endpackage

// File: rtl/nvm_guard_ctrl.sv
module nvm_guard_ctrl
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_OFS  = 3,
  parameter int PROT_OFS = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              keyEnable,
  output strobeT            stb
);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(PROT_OFS);

  logic hitCfg, hitProt;

  always_comb begin
    hitCfg      = (busAddr == CFG_A);
    hitProt     = (busAddr == PROT_A);
    stb.cfgWr   = busWrEn && hitCfg;
    stb.protWr  = busWrEn && hitProt;
    stb.keyWrOk = busWrEn && hitCfg && keyEnable;
    stb.rdCfg   = hitCfg;
    stb.rdProt  = hitProt;
  end
endmodule

// File: rtl/nvm_guard_dp.sv
module nvm_guard_dp
  import nvm_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] nvImage,
  input  logic              bufEmptyFlag,
  input  logic              cmdDoneFlag,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] protQ,
  output logic              irqReq,
  output logic              keyAccess
);
  logic cbeEn, ccEn;
  logic [DATA_W-1:0] protNext;
  logic [DATA_W-1:0] cfgByte;

  // configuration bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cbeEn     <= 1'b0;
      ccEn      <= 1'b0;
      keyAccess <= 1'b0;
    end else begin
      if (stb.cfgWr) begin
        cbeEn <= wrData[CFG_CBE_BIT];
        ccEn  <= wrData[CFG_CC_BIT];
      end
      if (stb.keyWrOk) keyAccess <= wrData[CFG_KEY_BIT];
    end
  end

  // protection: ratchet toward stronger protection only
  always_comb begin
    protNext = protQ;
    protNext[PROT_OPEN] = protQ[PROT_OPEN] & wrData[PROT_OPEN];
    protNext[PROT_HDIS] = protQ[PROT_HDIS] & wrData[PROT_HDIS];
    protNext[PROT_LDIS] = protQ[PROT_LDIS] & wrData[PROT_LDIS];
    if (protQ[PROT_HDIS]) protNext[PROT_HSZ+:2] = wrData[PROT_HSZ+:2];
    if (protQ[PROT_LDIS]) protNext[PROT_LSZ+:2] = wrData[PROT_LSZ+:2];
  end

  always_ff @(posedge clk) begin
    if (!rstN)           protQ <= nvImage;
    else if (stb.protWr) protQ <= protNext;
  end

  always_comb begin
    cfgByte = '0;
    cfgByte[CFG_CBE_BIT] = cbeEn;
    cfgByte[CFG_CC_BIT]  = ccEn;
    cfgByte[CFG_KEY_BIT] = keyAccess;
    if (stb.rdCfg)       rdData = cfgByte;
    else if (stb.rdProt) rdData = protQ;
    else                 rdData = '0;
    irqReq = (cbeEn && bufEmptyFlag) || (ccEn && cmdDoneFlag);
  end
endmodule

// File: rtl/nvm_guard_regs.sv
module nvm_guard_regs
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_OFS  = 3,
  parameter int PROT_OFS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic [7:0]        nvImage,
  input  logic              keyEnable,
  input  logic              bufEmptyFlag,
  input  logic              cmdDoneFlag,
  output logic              irqReq,
  output logic              keyWriteRoute,
  output logic              arrayReadInvalid
);
  strobeT     stb;
  logic [7:0] protQ;
  logic       keyAccess;

  nvm_guard_ctrl #(.ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .PROT_OFS(PROT_OFS)) ctrl_i (
    .busAddr(busAddr), .busWrEn(busWrEn), .keyEnable(keyEnable), .stb(stb)
  );

  nvm_guard_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData), .nvImage(nvImage),
    .bufEmptyFlag(bufEmptyFlag), .cmdDoneFlag(cmdDoneFlag),
    .rdData(busRdData), .protQ(protQ), .irqReq(irqReq), .keyAccess(keyAccess)
  );

  assign keyWriteRoute    = keyAccess;
  assign arrayReadInvalid = keyAccess;
endmodule

// File: rtl/nvm_guard_chk.sv
module nvm_guard_chk #(
  parameter int ADDR_W   = 4,
  parameter int CFG_OFS  = 3,
  parameter int PROT_OFS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              keyEnable,
  input logic              bufEmptyFlag,
  input logic              cmdDoneFlag,
  input logic [7:0]        busRdData,
  input logic              irqReq,
  input logic              keyWriteRoute,
  input logic [7:0]        protQ
);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(PROT_OFS);

  p_cfg_low_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == CFG_A) |-> (busRdData[4:0] == 5'd0));

  p_key_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == CFG_A && !keyEnable) |=> $stable(keyWriteRoute));

  p_irq_combine_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == CFG_A) |->
      (irqReq == ((busRdData[7] && bufEmptyFlag) || (busRdData[6] && cmdDoneFlag))));

  p_open_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !protQ[7] |=> !protQ[7]);
  p_hdis_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !protQ[5] |=> !protQ[5]);
  p_ldis_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !protQ[2] |=> !protQ[2]);

  p_nv_bit_fixed_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(protQ[6]));

  p_hsize_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    !protQ[5] |=> $stable(protQ[4:3]));
  p_lsize_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    !protQ[2] |=> $stable(protQ[1:0]));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != CFG_A && busAddr != PROT_A) |-> (busRdData == 8'h00));
endmodule

bind nvm_guard_regs nvm_guard_chk #(.ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .PROT_OFS(PROT_OFS)) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .keyEnable(keyEnable),
  .bufEmptyFlag(bufEmptyFlag), .cmdDoneFlag(cmdDoneFlag), .busRdData(busRdData),
  .irqReq(irqReq), .keyWriteRoute(keyWriteRoute), .protQ(protQ)
);

// File: tb/nvm_guard_regs_tb_top.sv
`timescale 1ns/1ps
module nvm_guard_regs_tb_top;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [7:0]    busWrData = '0;
  logic [7:0]    busRdData;
  logic [7:0]    nvImage = 8'hFF;
  logic          keyEnable = 1'b0;
  logic          bufEmptyFlag = 1'b0;
  logic          cmdDoneFlag = 1'b0;
  logic          irqReq, keyWriteRoute, arrayReadInvalid;

  int total = 0;
  int bad = 0;

  typedef struct {
    int         kind;   // 0 read data, 1 irq, 2 mode pair
    logic [7:0] exp;
    string      req;
  } itemT;
  itemT sbQ[$];
  event sampleEv;

  always #4 clk = ~clk;

  nvm_guard_regs #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .nvImage(nvImage),
    .keyEnable(keyEnable), .bufEmptyFlag(bufEmptyFlag), .cmdDoneFlag(cmdDoneFlag),
    .irqReq(irqReq), .keyWriteRoute(keyWriteRoute), .arrayReadInvalid(arrayReadInvalid)
  );

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(sampleEv);
      while (sbQ.size() > 0) begin
        itemT it;
        logic [7:0] act;
        it = sbQ.pop_front();
        case (it.kind)
          0:       act = busRdData;
          1:       act = {7'd0, irqReq};
          default: act = {6'd0, keyWriteRoute, arrayReadInvalid};
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string req);
    itemT it;
    it.kind = kind; it.exp = exp; it.req = req;
    sbQ.push_back(it);
    ->sampleEv;
    #1;
  endtask

  task automatic rdChk(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    busAddr = a;
    #1;
    push(0, exp, req);
  endtask

  task automatic irqChk(input logic be, input logic cd, input logic exp, input string req);
    @(negedge clk);
    bufEmptyFlag = be;
    cmdDoneFlag  = cd;
    busAddr      = 4'd3;
    #1;
    push(1, {7'd0, exp}, req);
  endtask

  task automatic modeChk(input logic exp, input string req);
    @(negedge clk);
    #1;
    push(2, {6'd0, exp, exp}, req);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic doReset(input logic [7:0] img);
    @(negedge clk);
    rstN = 1'b0; nvImage = img;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    doReset(8'hFF);
    rdChk(4'd3, 8'h00, "R1 cfg reset");
    rdChk(4'd4, 8'hFF, "R6 prot load");
    modeChk(1'b0, "R5 modes after reset");

    keyEnable = 1'b0;
    wr(4'd3, 8'hFF);
    rdChk(4'd3, 8'hC0, "R1 R2 R3 cfg write key locked");
    modeChk(1'b0, "R3 key still 0");
    irqChk(1'b1, 1'b0, 1'b1, "R4 buffer empty irq");
    irqChk(1'b0, 1'b1, 1'b1, "R4 cmd done irq");
    irqChk(1'b0, 1'b0, 1'b0, "R4 no flags");

    wr(4'd3, 8'h40);
    irqChk(1'b1, 1'b0, 1'b0, "R4 be masked");
    irqChk(1'b0, 1'b1, 1'b1, "R4 cc enabled");

    keyEnable = 1'b1;
    wr(4'd3, 8'h20);
    rdChk(4'd3, 8'h20, "R2 R3 key write allowed");
    modeChk(1'b1, "R5 key mode");
    keyEnable = 1'b0;
    wr(4'd3, 8'h00);
    rdChk(4'd3, 8'h20, "R3 key kept when locked");
    modeChk(1'b1, "R5 key mode kept");

    wr(4'd4, 8'hAE);
    rdChk(4'd4, 8'hEE, "R8 R9 sizes written");
    wr(4'd4, 8'hC6);
    rdChk(4'd4, 8'hC6, "R7 hdis cleared");
    wr(4'd4, 8'hFF);
    rdChk(4'd4, 8'hC7, "R7 R9 hdis sticky hsize frozen");
    wr(4'd4, 8'h7B);
    rdChk(4'd4, 8'h43, "R7 open and ldis cleared");
    wr(4'd4, 8'hFC);
    rdChk(4'd4, 8'h43, "R7 R9 lsize frozen");

    rdChk(4'd0, 8'h00, "R10 unmapped read 0");
    wr(4'd5, 8'hFF);
    rdChk(4'd5, 8'h00, "R10 unmapped read 5");
    rdChk(4'd3, 8'h20, "R10 cfg untouched");
    rdChk(4'd4, 8'h43, "R10 prot untouched");

    doReset(8'h3A);
    rdChk(4'd4, 8'h3A, "R6 second image");
    rdChk(4'd3, 8'h00, "R1 cfg reset again");
    wr(4'd4, 8'hFF);
    rdChk(4'd4, 8'h3A, "R7 R8 R9 no weakening");

    @(negedge clk);
    if (sbQ.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard residue actual=%0d expected=0", sbQ.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule